// File: doc/BRIEF.md
# Video Sync Delay and Field Detector

This block sits at the input of a video timing path and works on the input pixel clock. It receives the horizontal and vertical sync of the incoming picture and produces three things from them. The first is an internal vertical sync that is moved later by a programmable coarse number of clocks. The second is a flag that says whether the current field is the first or the second field of an interlaced frame. The third is an output vertical sync placed a programmable number of lines after the internal one.

The field decision is made when the internal vertical sync occurs. At that moment the block compares the position inside the current line with half of the measured line length. An optional tolerant filter for sources with irregular field order forces the reported flag to alternate, and a polarity bit can invert the reported flag.

Configuration is written through a small parallel port: an address, data and a write strobe. Written values are held in a shadow copy. They reach the working logic only at the next internal vertical sync, so a field that is in progress always uses one consistent set of settings.

Top module: `vsync_field_timer`

## Requirements
- R1: After reset, `vdly_pulse`, `vsync_out` and `field_flag` are 0. `vsync_out` stays 0 until the first internal pulse, however many lines pass before it.
- R2: A rising edge on `vsync_in` makes `vdly_pulse` high for exactly one cycle, coarse×128+1 cycles after the edge is seen. Edges are seen through a 2-flop synchronizer, so the pulse appears coarse×128+3 cycles after the input is driven high.
- R3: A new rising edge on `vsync_in` while a delay is still counting restarts the delay. No pulse is issued for the earlier edge.
- R4: At each pulse the block captures a raw field value. The horizontal position is the number of clocks since the last synchronized `hsync_in` rising edge, and the line length is the measured period between the last two such edges. A position below half the line length gives raw 0 (first field); any other position gives raw 1. From the cycle after the pulse, `field_flag` holds its new value until the next pulse.
- R5: Bit 0 at address 0x00 is the invert bit. When it is 1, the reported flag is the filtered or raw value inverted, so the first field reads as 1.
- R6: Bit 1 at address 0x00 enables the filter. The filter keeps the previous raw value and a filtered value, both 0 after reset. At each pulse, if the new raw value equals the previous raw value, the filtered value toggles; otherwise it takes the raw value. With the filter enabled the reported flag is the filtered value; with it disabled, the reported flag is the raw value.
- R7: Address 0x01 (data bits 7:0) holds the coarse delay. Address 0x06 (data bits 8:0) holds the line delay. Every write reaches the working logic only at the next pulse. Before that pulse the outputs behave as before the write.
- R8: Reset values: coarse delay 0, invert 0, filter enabled, line delay 170.
- R9: A line counter clears at each pulse and counts synchronized `hsync_in` rising edges. `vsync_out` is high exactly while the count equals the line delay, so a line delay of 0 gives a pulse from the internal sync up to the next horizontal edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Incoming horizontal sync, active high |
| vsync_in | input | 1 | Incoming vertical sync, active high |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Configuration address |
| wr_data | input | 9 | Configuration write data |
| vdly_pulse | output | 1 | Internal delayed vertical sync, one cycle |
| field_flag | output | 1 | Reported field (after filter and inversion) |
| vsync_out | output | 1 | Output vertical sync, one line long |

## Verification
The delay is swept over the first four coarse settings, which separates a wrong step size from a wrong fixed offset. A second edge arriving mid-count shows whether the counter restarts. The vertical sync is stepped through thirty positions within a line, including both sides of the half-line boundary, with the filter off, then with inversion alone. Irregular sequences such as AAAB and BB are then applied with the filter on, which separates following the raw value from forced alternation. Line delays of 0, 1, 2, 5 and the reset value of 170 are walked line by line to locate the output pulse. Each setting is written mid-field first, to show it is not applied before the next internal sync.

// File: rtl/vft_pkg.sv
package vft_pkg;

    localparam int COARSE_W = 8;
    localparam int LINE_W   = 9;
    localparam int H_W      = 12;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 9;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_VDLY = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_LDLY = 8'h06;

    localparam logic [LINE_W-1:0] LDLY_RESET = LINE_W'(170);

    typedef enum logic {
        FIELD_A = 1'b0,
        FIELD_B = 1'b1
    } field_e;

    typedef struct packed {
        logic [LINE_W-1:0]   line_dly;
        logic [COARSE_W-1:0] coarse;
        logic                filt_en;
        logic                inv;
    } cfg_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.line_dly = LDLY_RESET;
        c.coarse   = '0;
        c.filt_en  = 1'b1;
        c.inv      = 1'b0;
        return c;
    endfunction

    function automatic field_e classify(logic [H_W-1:0] pos, logic [H_W-1:0] len);
        return (pos < (len >> 1)) ? FIELD_A : FIELD_B;
    endfunction

endpackage

// File: rtl/vft_sync.sv
module vft_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], d};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/vft_regs.sv
module vft_regs import vft_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output cfg_t              active
);
    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= cfg_reset();
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: begin
                    shadow.inv     <= wr_data[0];
                    shadow.filt_en <= wr_data[1];
                end
                ADDR_VDLY: shadow.coarse   <= wr_data[COARSE_W-1:0];
                ADDR_LDLY: shadow.line_dly <= wr_data[LINE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       active <= cfg_reset();
        else if (load) active <= shadow;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active)); // R7
endmodule

// File: rtl/vft_vdelay.sv
module vft_vdelay #(
    parameter int COARSE_BITS = 8,
    parameter int SHIFT       = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   vs_rise,
    input  logic [COARSE_BITS-1:0] coarse,
    output logic                   pulse
);
    localparam int CNT_W = COARSE_BITS + SHIFT;

    logic [CNT_W-1:0] cnt;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (vs_rise) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(coarse) << SHIFT;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end
    end

    assign pulse = busy && (cnt == '0);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse && !vs_rise |=> !pulse); // R2
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        vs_rise && (coarse != '0) |=> !pulse); // R3
endmodule

// File: rtl/vft_timing.sv
module vft_timing import vft_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              hs_rise,
    input  logic              vdly_pulse,
    input  logic              filt_en,
    input  logic              inv,
    input  logic [LINE_W-1:0] line_dly,
    output logic              field_flag,
    output logic              vsync_out
);
    localparam int LC_W = LINE_W + 1;

    logic [H_W-1:0]  hcnt, line_len;
    field_e          raw_now;
    logic            raw_q, prev_raw, filt;
    logic [LC_W-1:0] lcnt;
    logic            armed;

    // horizontal position and measured line period
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt     <= '0;
            line_len <= '0;
        end else if (hs_rise) begin
            hcnt     <= '0;
            line_len <= hcnt + H_W'(1);
        end else if (hcnt != '1) begin
            hcnt <= hcnt + H_W'(1);
        end
    end

    assign raw_now = classify(hcnt, line_len);

    // field capture and alternation filter
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q    <= 1'b0;
            prev_raw <= 1'b0;
            filt     <= 1'b0;
        end else if (vdly_pulse) begin
            raw_q    <= logic'(raw_now);
            prev_raw <= logic'(raw_now);
            filt     <= (logic'(raw_now) == prev_raw) ? ~filt : logic'(raw_now);
        end
    end

    assign field_flag = (filt_en ? filt : raw_q) ^ inv;

    // line counter for the output sync
    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt  <= '0;
            armed <= 1'b0;
        end else if (vdly_pulse) begin
            lcnt  <= '0;
            armed <= 1'b1;
        end else if (hs_rise && lcnt != '1) begin
            lcnt <= lcnt + LC_W'(1);
        end
    end

    assign vsync_out = armed && (lcnt == {1'b0, line_dly});

    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vdly_pulse |=> $stable(field_flag)); // R4
    AST_FILTER_ALT: assert property (@(posedge clk) disable iff (rst)
        vdly_pulse && (logic'(raw_now) == prev_raw) |=> filt != $past(filt)); // R6
    AST_VOUT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_out) |-> $past(hs_rise || vdly_pulse)); // R9
    AST_VOUT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_out) |-> $past(hs_rise || vdly_pulse)); // R9
endmodule

// File: rtl/vsync_field_timer.sv
module vsync_field_timer import vft_pkg::*; #(
    parameter int SYNC_STAGES  = 2,
    parameter int COARSE_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              vdly_pulse,
    output logic              field_flag,
    output logic              vsync_out
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] pin_in, pin_rise;
    cfg_t              cfg;

    assign pin_in = {vsync_in, hsync_in};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        vft_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .d    (pin_in[g]),
            .rise (pin_rise[g])
        );
    end

    vft_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (vdly_pulse),
        .active  (cfg)
    );

    vft_vdelay #(.COARSE_BITS(COARSE_W), .SHIFT(COARSE_SHIFT)) u_vdelay (
        .clk     (clk),
        .rst     (rst),
        .vs_rise (pin_rise[1]),
        .coarse  (cfg.coarse),
        .pulse   (vdly_pulse)
    );

    vft_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .hs_rise    (pin_rise[0]),
        .vdly_pulse (vdly_pulse),
        .filt_en    (cfg.filt_en),
        .inv        (cfg.inv),
        .line_dly   (cfg.line_dly),
        .field_flag (field_flag),
        .vsync_out  (vsync_out)
    );
endmodule

// File: tb/test_vsync_field_timer.sv
module test_vsync_field_timer;
    localparam int LINE = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0, vsync_in = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic       vdly_pulse, field_flag, vsync_out;

    int n_checks = 0, n_fail = 0, hpos = 0;
    bit done = 0;

    // bench model of the configuration and the field filter
    int sh_coarse = 0, ac_coarse = 0, sh_line = 170, ac_line = 170;
    bit sh_inv = 0, ac_inv = 0, sh_filt = 1, ac_filt = 1;
    bit m_prev = 0, m_filt = 0;

    vsync_field_timer i_vsync_field_timer (
        .clk, .rst, .hsync_in, .vsync_in, .wr_en, .wr_addr, .wr_data,
        .vdly_pulse, .field_flag, .vsync_out
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        hpos = (hpos + 1) % LINE;
        hsync_in = (hpos < 4);
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        wr_addr = a; wr_data = 9'(d); wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        case (a)
            8'h00: begin sh_inv = d[0]; sh_filt = d[1]; end
            8'h01: sh_coarse = d & 8'hff;
            8'h06: sh_line = d & 9'h1ff;
            default: ;
        endcase
    endtask

    // model update at a pulse observed at hpos h, then field check one cycle later
    task automatic after_pulse(input int h, input string tag);
        bit raw, exp;
        ac_coarse = sh_coarse; ac_line = sh_line; ac_inv = sh_inv; ac_filt = sh_filt;
        raw = (h >= 23 || h <= 2);
        if (raw == m_prev) m_filt = ~m_filt; else m_filt = raw;
        m_prev = raw;
        exp = (ac_filt ? m_filt : raw) ^ ac_inv;
        tick();
        check("R2 pulse one cycle", vdly_pulse, 1'b0);
        check(tag, field_flag, exp);
    endtask

    task automatic fire(input int p, input string tag, output int h_obs);
        int d = ac_coarse * 128 + 1;
        bit early = 0;
        do tick(); while (hpos != p);
        vsync_in = 1'b1;
        for (int n = 1; n <= d + 2; n++) begin
            tick();
            if (n == 3) vsync_in = 1'b0;
            if (n < d + 2 && vdly_pulse) early = 1;
        end
        vsync_in = 1'b0;
        check("R2 no early pulse", early, 1'b0);
        check("R2 pulse at coarse*128+3", vdly_pulse, 1'b1);
        h_obs = hpos;
        after_pulse(h_obs, tag);
    endtask

    // sample vsync_out mid-line for line indices 0..last after a pulse at h_obs
    task automatic walk(input int h_obs, input int last, input string tag);
        if (h_obs <= 19) begin
            while (hpos != 20) tick();
            check(tag, vsync_out, ac_line == 0);
        end
        for (int j = 1; j <= last; j++) begin
            do tick(); while (hpos != 20);
            check(tag, vsync_out, ac_line == j);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int h;
        bit early;
        int seq[10];
        repeat (5) tick();
        rst = 1'b0;
        tick();
        check("R1 vdly_pulse after reset", vdly_pulse, 1'b0);
        check("R1 vsync_out after reset", vsync_out, 1'b0);
        check("R1 field_flag after reset", field_flag, 1'b0);
        repeat (3 * LINE) tick();
        check("R1 vsync_out idle before first pulse", vsync_out, 1'b0);

        // R8: defaults - coarse 0, filter on, line delay 170
        fire(5, "R8 filter on by default", h);
        walk(h, 172, "R8 R9 default line delay 170");

        // R2 / R7: coarse delay sweep, each write taking effect one pulse later
        for (int k = 0; k < 4; k++) begin
            wr(8'h01, k);
            fire(5, "R7 field after coarse write", h);
            fire(5, "R2 field with coarse delay", h);
        end

        // R3: restart on a second edge mid-count (coarse 2, 257 cycles)
        wr(8'h01, 2);
        fire(5, "R7 field", h);
        do tick(); while (hpos != 5);
        vsync_in = 1'b1;
        early = 0;
        for (int n = 1; n <= 60 + 257 + 2; n++) begin
            tick();
            if (n == 3 || n == 63) vsync_in = 1'b0;
            if (n == 60) vsync_in = 1'b1;
            if (n < 319 && vdly_pulse) early = 1;
        end
        check("R3 no pulse for abandoned edge", early, 1'b0);
        check("R3 pulse from restarted edge", vdly_pulse, 1'b1);
        after_pulse(hpos, "R3 field after restart");

        // R4: position sweep, filter off, no inversion
        wr(8'h01, 0);
        wr(8'h00, 0);
        check("R7 mode write not yet active", field_flag, (ac_filt ? m_filt : m_prev) ^ ac_inv);
        fire(5, "R7 mode applied", h);
        for (int p = 5; p <= 34; p++) fire(p, "R4 raw field by position", h);

        // R5: inversion, checked first mid-field (R7), then applied
        fire(7, "R4 field A", h);
        wr(8'h00, 1);
        repeat (5) tick();
        check("R7 invert held until next pulse", field_flag, 1'b0);
        fire(7, "R5 inverted field A", h);
        fire(27, "R5 inverted field B", h);
        fire(19, "R5 inverted boundary A", h);
        fire(20, "R5 inverted boundary B", h);

        // R6: filter on irregular orders: A A A B A A A B B B
        wr(8'h00, 2);
        fire(7, "R7 filter applied", h);
        seq = '{7, 7, 7, 27, 7, 7, 7, 27, 27, 27};
        foreach (seq[i]) fire(seq[i], "R6 filtered field", h);
        wr(8'h00, 3);
        fire(27, "R6 filter with invert", h);
        for (int i = 0; i < 4; i++) fire(7, "R6 filter with invert", h);

        // R9: line delay sweep
        foreach (seq[i]) if (i < 4) begin
            int v = (i == 3) ? 5 : i;
            wr(8'h06, v);
            fire(5, "R9 field", h);
            walk(h, v + 2, "R9 output sync line");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule